// File: doc/BRIEF.md
# Input Capture Channel

This block timestamps transitions on one external input pin. The pin goes through a two-flop synchronizer. A 3-bit mode field selects which transitions count as capture events: every transition, only falling transitions, only rising transitions, or every 4th or 16th rising transition. On each event the block latches one of two 16-bit free-running time bases into a 4-entry FIFO.

A software-facing wrapper, which is not part of this block, reads the FIFO through a read strobe. It watches a not-empty status and a sticky overflow status. The block raises a one-cycle interrupt pulse after a programmable number of stored captures. A separate wake mode pulses the interrupt on any pin transition and stores nothing.

Top module: `capture_channel`

## Requirements
- R1: A pin level is held in two synchronizer flops before edge detection. A rising level driven ahead of clock edge k, in rising-capture mode with an empty FIFO, makes `not_empty` go high after edge k+2 and not earlier.
- R2: Mode 3'b001 captures on both rising and falling transitions. Mode 3'b010 captures only on falling transitions. Mode 3'b011 captures only on rising transitions.
- R3: Mode 3'b100 captures on every 4th rising transition and mode 3'b101 on every 16th. Any change of `mode` clears the prescale count. A rising transition detected in the same cycle as the change is not counted.
- R4: Mode 3'b111 pulses `irq` for one cycle on each rising or falling transition and never writes the FIFO.
- R5: The captured value is `tmr_a` when `tmr_sel` is 0 and `tmr_b` when `tmr_sel` is 1. It is sampled at the clock edge that stores the capture.
- R6: The FIFO holds 4 values and returns them oldest first. A cycle with `rd_en` high and a non-empty FIFO loads the oldest value into `rd_data` at that clock edge. `rd_en` on an empty FIFO leaves `rd_data` and the FIFO unchanged. `not_empty` is high whenever at least one value is held.
- R7: `irq` pulses for one cycle in the cycle after the (N+1)-th stored capture, where N is `irq_every` (2'b00 means every capture). The capture count then restarts.
- R8: A capture that arrives while the FIFO is full and no read happens in that cycle is dropped, and `overflow` is set. `overflow` stays set until a read removes the last held value while no capture is written in that cycle.
- R9: Mode 3'b000 empties the FIFO and clears `overflow`, the prescale count and the interrupt count. Modes 3'b000 and 3'b110 store nothing.
- R10: After reset `not_empty`, `overflow` and `irq` are 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin | input | 1 | Asynchronous capture input |
| tmr_a | input | 16 | First time base |
| tmr_b | input | 16 | Second time base |
| mode | input | 3 | Event mode select |
| tmr_sel | input | 1 | Time base select |
| irq_every | input | 2 | Captures per interrupt, minus one |
| rd_en | input | 1 | FIFO read strobe |
| rd_data | output | 16 | Last value read from the FIFO |
| not_empty | output | 1 | FIFO holds at least one value |
| overflow | output | 1 | Sticky: a capture was dropped |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its default parameters: 16-bit stamps, a 4-deep FIFO and prescale divisors of 4 and 16. With these values a burst of five or six rising transitions reaches the full and overflow conditions. Thirty-two pulses cross the 16-count prescale boundary twice. The 2-bit interrupt count wraps within a short run. A behavioural queue model steps beside the design, so the long randomized phase can change mode at any time, including in the middle of a prescale count and while the FIFO is full.

// File: rtl/capture_channel.sv
module capture_channel #(
  parameter int TW    = 16,
  parameter int DEPTH = 4,
  parameter int PRE_A = 4,
  parameter int PRE_B = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic [TW-1:0] tmr_a,
  input  logic [TW-1:0] tmr_b,
  input  logic [2:0]    mode,
  input  logic          tmr_sel,
  input  logic [1:0]    irq_every,
  input  logic          rd_en,
  output logic [TW-1:0] rd_data,
  output logic          not_empty,
  output logic          overflow,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(PRE_B);

  logic [1:0]    sync;
  logic          prev;
  logic [2:0]    mode_q;
  logic [PW-1:0] pcnt;
  logic [1:0]    icnt;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [TW-1:0] mem [DEPTH];
  logic          ev;

  wire rise     = sync[1] & ~prev;
  wire fall     = ~sync[1] & prev;
  wire mode_chg = mode != mode_q;
  wire pre_mode = (mode == 3'b100) || (mode == 3'b101);
  wire [PW-1:0] pre_top = (mode == 3'b100) ? PW'(PRE_A - 1) : PW'(PRE_B - 1);
  wire pre_hit  = pre_mode & ~mode_chg & rise & (pcnt == pre_top);

  always_comb begin
    case (mode)
      3'b001:         ev = rise | fall;
      3'b010:         ev = fall;
      3'b011:         ev = rise;
      3'b100, 3'b101: ev = pre_hit;
      default:        ev = 1'b0;
    endcase
  end

  wire off  = mode == 3'b000;
  wire wake = (mode == 3'b111) & (rise | fall);
  wire full = cnt == CW'(DEPTH);
  wire rd   = rd_en & (cnt != '0) & ~off;
  wire wr   = ev & (~full | rd);
  wire drop = ev & full & ~rd;
  wire [TW-1:0] stamp = tmr_sel ? tmr_b : tmr_a;

  assign not_empty = cnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync   <= '0;
      prev   <= 1'b0;
      mode_q <= 3'b000;
      pcnt   <= '0;
    end else begin
      sync   <= {sync[0], pin};
      prev   <= sync[1];
      mode_q <= mode;
      if (!pre_mode || mode_chg)
        pcnt <= '0;
      else if (rise)
        pcnt <= (pcnt == pre_top) ? '0 : pcnt + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      icnt     <= '0;
      overflow <= 1'b0;
      irq      <= 1'b0;
      rd_data  <= '0;
    end else if (off) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      icnt     <= '0;
      overflow <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr)
        wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (rd) begin
        rd_data <= mem[rptr];
        rptr    <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      end
      cnt <= cnt + CW'(wr) - CW'(rd);
      if (drop)
        overflow <= 1'b1;
      else if (rd && cnt == CW'(1) && !wr)
        overflow <= 1'b0;
      irq <= (wr & (icnt == irq_every)) | wake;
      if (wr)
        icnt <= (icnt == irq_every) ? 2'd0 : icnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr)
      mem[wptr] <= stamp;
  end
endmodule

// File: rtl/capture_channel_chk.sv
module capture_channel_chk #(
  parameter int TW    = 16,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic          rd_en,
  input logic [TW-1:0] rd_data,
  input logic          not_empty,
  input logic          overflow,
  input logic          irq,
  input logic [CW-1:0] cnt
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R6
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && rd_en) |=> $stable(rd_data)); // R6
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && mode != 3'b000 && !(rd_en && not_empty)) |=> overflow); // R8
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000) |=> (!not_empty && !overflow && !irq)); // R9
  AST_WAKE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b111 && !not_empty) |=> !not_empty); // R4
endmodule

bind capture_channel capture_channel_chk #(.TW(TW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rd_en(rd_en), .rd_data(rd_data),
  .not_empty(not_empty), .overflow(overflow), .irq(irq), .cnt(cnt)
);

// File: tb/capture_channel_test.sv
module capture_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] tmr_a = '0, tmr_b = '0;
  logic [2:0]  mode = 3'b000;
  logic        tmr_sel = 1'b0;
  logic [1:0]  irq_every = 2'b00;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        not_empty, overflow, irq;

  capture_channel uut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R10 reset";

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, phase, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] q[$];
  bit m_s1, m_s2, m_prev, m_ovf, m_irq;
  logic [15:0] m_rd;
  int m_pc, m_ic;
  logic [2:0] m_mode_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      {m_s1, m_s2, m_prev, m_ovf, m_irq} = '0;
      m_rd = '0; m_pc = 0; m_ic = 0; m_mode_prev = 3'b000;
    end else begin
      bit rise, fall, ev, rd, wr, drop, chg;
      int lim;
      rise = m_s2 && !m_prev;
      fall = !m_s2 && m_prev;
      chg  = mode != m_mode_prev;
      lim  = (mode == 3'b100) ? 4 : 16;
      case (mode)
        3'b001: ev = rise || fall;
        3'b010: ev = fall;
        3'b011: ev = rise;
        3'b100, 3'b101: ev = rise && !chg && (m_pc == lim - 1);
        default: ev = 0;
      endcase
      if (!(mode == 3'b100 || mode == 3'b101) || chg) m_pc = 0;
      else if (rise) m_pc = (m_pc == lim - 1) ? 0 : m_pc + 1;
      if (mode == 3'b000) begin
        q.delete(); m_ovf = 0; m_ic = 0; m_irq = 0;
      end else begin
        rd   = rd_en && q.size() > 0;
        wr   = ev && (q.size() < 4 || rd);
        drop = ev && q.size() == 4 && !rd;
        if (rd) m_rd = q.pop_front();
        if (wr) q.push_back(tmr_sel ? tmr_b : tmr_a);
        if (drop) m_ovf = 1;
        else if (rd && q.size() == 0) m_ovf = 0;
        m_irq = (wr && m_ic == int'(irq_every)) || (mode == 3'b111 && (rise || fall));
        if (wr) m_ic = (m_ic == int'(irq_every)) ? 0 : (m_ic + 1) % 4;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
      m_mode_prev = mode;
    end
  end

  int tick = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rd_data == m_rd, "R6", "rd_data", rd_data, m_rd);
      check(not_empty == (q.size() > 0), "R6", "not_empty", not_empty, q.size() > 0);
      check(overflow == m_ovf, "R8", "overflow", overflow, m_ovf);
      check(irq == m_irq, "R7", "irq", irq, m_irq);
    end
    tick++;
    tmr_a = 16'(tick);
    tmr_b = 16'(tick * 7 + 3);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n, int hi, int lo);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; step(hi);
      pin = 1'b0; step(lo);
    end
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      rd_en = 1'b1; step();
      rd_en = 1'b0; step();
    end
  endtask

  initial begin
    step(3);
    check(not_empty == 0 && overflow == 0 && irq == 0 && rd_data == 0, "R10",
          "reset outputs", {not_empty, overflow, irq}, 0);
    rst_n = 1'b1; step(2);

    phase = "R1 latency";
    mode = 3'b011; step(3);
    pin = 1'b1; step(2);
    check(not_empty == 0, "R1", "not_empty two edges after pin", not_empty, 0);
    step();
    check(not_empty == 1, "R1", "not_empty three edges after pin", not_empty, 1);
    pin = 1'b0; step(3);
    drain(2);

    phase = "R2 both edges";
    mode = 3'b001; step(2);
    pulses(2, 3, 3); drain(5);
    phase = "R2 falling";
    mode = 3'b010; step(2);
    pulses(3, 2, 4); drain(4);
    phase = "R2 rising";
    mode = 3'b011; pulses(3, 4, 2); drain(4);

    phase = "R5 second timer";
    tmr_sel = 1'b1; pulses(2, 3, 3); drain(3);
    tmr_sel = 1'b0;

    phase = "R3 divide by 4";
    mode = 3'b100; step(2);
    pulses(9, 2, 2); drain(3);
    phase = "R3 divide by 16";
    mode = 3'b101; step(2);
    pulses(34, 2, 2); drain(3);
    phase = "R3 mode change restarts count";
    mode = 3'b100; pulses(2, 2, 2);
    mode = 3'b101; pulses(3, 2, 2);
    mode = 3'b100; pulses(5, 2, 2); drain(3);

    phase = "R7 irq after 3";
    mode = 3'b011; irq_every = 2'b10;
    pulses(7, 2, 2); drain(4);
    phase = "R7 irq after 4";
    irq_every = 2'b11; pulses(4, 2, 2); drain(5);

    phase = "R8 overflow";
    mode = 3'b000; step(2);
    mode = 3'b011; irq_every = 2'b00;
    pulses(6, 2, 2); step(3);
    check(overflow == 1, "R8", "overflow after 6 captures", overflow, 1);
    drain(5);
    check(overflow == 0, "R8", "overflow after emptying", overflow, 0);

    phase = "R4 wake";
    mode = 3'b111; step(2);
    pulses(3, 3, 3); step(3);
    check(not_empty == 0, "R4", "wake mode stores nothing", not_empty, 0);

    phase = "R9 off clears";
    mode = 3'b011; pulses(6, 2, 2); step(3);
    mode = 3'b000; step(2);
    check(not_empty == 0 && overflow == 0, "R9", "off clears fifo",
          {not_empty, overflow}, 0);
    phase = "R9 reserved mode";
    mode = 3'b110; pulses(3, 2, 2); step(3);
    check(not_empty == 0, "R9", "mode 110 stores nothing", not_empty, 0);

    phase = "R6 random mix";
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        mode = 3'($urandom % 8);
        tmr_sel = 1'($urandom % 2);
        irq_every = 2'($urandom % 4);
      end
      if ($urandom % 3 == 0) pin = ~pin;
      rd_en = ($urandom % 6 == 0);
      step();
    end
    rd_en = 1'b0; step(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000ns;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog [%s] run did not finish actual=1 expected=0", phase);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule